// File: doc/BRIEF.md
# Security-Aware Interrupt Group Router

This block collects a parameterised number of interrupt sources and turns them into the two processor interrupt lines, IRQ and FIQ. Every source sits in one of three groups: a secure group served by the highest-privilege firmware (Group 0), a secure group served by the trusted OS (Secure Group 1), and a non-secure group (Non-secure Group 1). Which line a pending, enabled source drives depends on its group and on the security state the processor is in at that moment. Group 0 always drives FIQ. A Group 1 source drives IRQ when the processor is in the source's own world, and FIQ otherwise.

Software configures the block through a simple register port. Every request carries a secure/non-secure tag. Only secure requests may change group assignments, and they may do so at run time. A non-secure request can neither see nor change any field that belongs to a secure source. Hardware sources set pending bits directly with level inputs.

Top module: `sec_irq_router`

## Requirements
- R1: After synchronous reset every source is Group 0 (group bit 0, modifier bit 0), disabled and not pending. IRQ and FIQ are low, and every register reads 0.
- R2: An enabled, pending Group 0 source drives FIQ and never IRQ, in either processor security state.
- R3: An enabled, pending Secure Group 1 source (group bit 0, modifier bit 1) drives IRQ while `cpu_nonsecure_i` is 0 and FIQ while it is 1.
- R4: An enabled, pending Non-secure Group 1 source (group bit 1) drives FIQ while `cpu_nonsecure_i` is 0 and IRQ while it is 1.
- R5: A source whose enable bit is 0 drives neither line, whether it is pending or not.
- R6: The group register (selector 0) and the modifier register (selector 1) change only on secure writes. Non-secure writes to them are ignored.
- R7: Writes to enable-set (2), enable-clear (3), pending-set (4) and pending-clear (5) act on every bit when secure. When non-secure, they act only on bits whose group bit is 1.
- R8: A read returns the addressed field one cycle later with `rd_valid_o` high. Reading selector 2 or 3 gives the enable bits, and 4 or 5 gives the pending bits. On a non-secure read, every bit whose group bit is 0 reads 0.
- R9: IRQ and FIQ are registered. They change on the clock edge after the edge that changed pending, enable, group or security state.
- R10: A high `src_set_i` bit sets that source's pending bit. If a pending-clear write hits the same bit in the same cycle, the set wins.
- R11: A secure change of group assignment at run time reroutes an already pending source on the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cpu_nonsecure_i | input | 1 | Processor security state, 1 = non-secure |
| src_set_i | input | N_SRC | Per-source level request that sets pending |
| req_valid_i | input | 1 | Register request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Request security tag, 1 = secure |
| req_sel_i | input | 3 | Register selector (0 group, 1 modifier, 2 enable-set, 3 enable-clear, 4 pending-set, 5 pending-clear) |
| req_wdata_i | input | N_SRC | Write data, one bit per source |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | N_SRC | Read data, masked for non-secure reads |
| irq_o | output | 1 | IRQ line |
| fiq_o | output | 1 | FIQ line |

## Verification
The bench builds the block with the default of eight sources. Eight sources are enough to hold all three groups at once with distinct bit patterns such as 0xA5 and 0xF0. This lets a single access show non-secure masking on secure bits right next to unmasked non-secure bits. Each routing case is driven in both processor security states. One case switches the group of a source that is already pending. Another puts a hardware set on the same cycle as a clear write.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    typedef enum logic [1:0] {
        GRP_SEC0 = 2'd0,
        GRP_SEC1 = 2'd1,
        GRP_NS1  = 2'd2
    } irq_grp_e;

    typedef enum logic [2:0] {
        SEL_GROUP    = 3'd0,
        SEL_MOD      = 3'd1,
        SEL_EN_SET   = 3'd2,
        SEL_EN_CLR   = 3'd3,
        SEL_PEND_SET = 3'd4,
        SEL_PEND_CLR = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic     valid;
        logic     write;
        logic     secure;
        reg_sel_e sel;
    } reg_req_t;

    typedef struct packed {
        logic to_irq;
        logic to_fiq;
    } route_t;

    function automatic irq_grp_e decode_grp(input logic grp_bit, input logic mod_bit);
        if (grp_bit)      return GRP_NS1;
        else if (mod_bit) return GRP_SEC1;
        else              return GRP_SEC0;
    endfunction

    function automatic route_t route_of(input irq_grp_e grp, input logic cpu_ns);
        route_t r;
        unique case (grp)
            GRP_SEC0: r = '{to_irq: 1'b0,    to_fiq: 1'b1};
            GRP_SEC1: r = '{to_irq: !cpu_ns, to_fiq: cpu_ns};
            GRP_NS1:  r = '{to_irq: cpu_ns,  to_fiq: !cpu_ns};
            default:  r = '{to_irq: 1'b0,    to_fiq: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  reg_req_t         req_i,
    input  logic [N_SRC-1:0] wdata_i,
    input  logic [N_SRC-1:0] src_set_i,
    output logic [N_SRC-1:0] grp_o,
    output logic [N_SRC-1:0] mod_o,
    output logic [N_SRC-1:0] en_o,
    output logic [N_SRC-1:0] pend_o,
    output logic             rvalid_o,
    output logic [N_SRC-1:0] rdata_o
);

    logic [N_SRC-1:0] grp_q, mod_q, en_q, pend_q;
    logic [N_SRC-1:0] side_mask;
    logic [N_SRC-1:0] wr_bits;
    logic [N_SRC-1:0] pend_set, pend_clr;
    logic [N_SRC-1:0] rd_field;
    logic             wr_act, rd_act;
    logic             past_ok;

    assign wr_act    = req_i.valid && req_i.write;
    assign rd_act    = req_i.valid && !req_i.write;
    assign side_mask = req_i.secure ? {N_SRC{1'b1}} : grp_q;
    assign wr_bits   = wdata_i & side_mask;

    always_comb begin
        pend_set = src_set_i;
        pend_clr = '0;
        if (wr_act && req_i.sel == SEL_PEND_SET) pend_set = pend_set | wr_bits;
        if (wr_act && req_i.sel == SEL_PEND_CLR) pend_clr = wr_bits;
    end

    always_comb begin
        unique case (req_i.sel)
            SEL_GROUP:                rd_field = grp_q;
            SEL_MOD:                  rd_field = mod_q;
            SEL_EN_SET, SEL_EN_CLR:   rd_field = en_q;
            SEL_PEND_SET, SEL_PEND_CLR: rd_field = pend_q;
            default:                  rd_field = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            grp_q    <= '0;
            mod_q    <= '0;
            en_q     <= '0;
            pend_q   <= '0;
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
            past_ok  <= 1'b0;
        end else begin
            past_ok  <= 1'b1;
            rvalid_o <= rd_act;
            rdata_o  <= rd_act ? (rd_field & side_mask) : '0;
            pend_q   <= (pend_q & ~pend_clr) | pend_set;
            if (wr_act) begin
                unique case (req_i.sel)
                    SEL_GROUP:  if (req_i.secure) grp_q <= wdata_i;
                    SEL_MOD:    if (req_i.secure) mod_q <= wdata_i;
                    SEL_EN_SET: en_q <= en_q | wr_bits;
                    SEL_EN_CLR: en_q <= en_q & ~wr_bits;
                    default: ;
                endcase
            end
        end
    end

    assign grp_o  = grp_q;
    assign mod_o  = mod_q;
    assign en_o   = en_q;
    assign pend_o = pend_q;

    // R6
    grp_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        past_ok && $past(wr_act && !req_i.secure &&
                         (req_i.sel == SEL_GROUP || req_i.sel == SEL_MOD))
        |-> (grp_q == $past(grp_q)) && (mod_q == $past(mod_q)));

    // R7
    ns_en_iso_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        past_ok && $past(wr_act && !req_i.secure &&
                         (req_i.sel == SEL_EN_SET || req_i.sel == SEL_EN_CLR))
        |-> ((en_q & ~$past(grp_q)) == ($past(en_q) & ~$past(grp_q))));

    // R8
    ns_read_mask_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        past_ok && $past(rd_act && !req_i.secure)
        |-> ((rdata_o & ~$past(grp_q)) == '0) && rvalid_o);

endmodule

// File: rtl/irq_group_map.sv
module irq_group_map
    import irq_route_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic [N_SRC-1:0] grp_i,
    input  logic [N_SRC-1:0] mod_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] pend_i,
    input  logic             cpu_ns_i,
    output logic             irq_any_o,
    output logic             fiq_any_o
);

    logic [N_SRC-1:0] irq_vec, fiq_vec;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        irq_grp_e grp;
        route_t   rt;
        logic     live;
        assign grp        = decode_grp(grp_i[i], mod_i[i]);
        assign rt         = route_of(grp, cpu_ns_i);
        assign live       = en_i[i] && pend_i[i];
        assign irq_vec[i] = live && rt.to_irq;
        assign fiq_vec[i] = live && rt.to_fiq;
    end

    assign irq_any_o = |irq_vec;
    assign fiq_any_o = |fiq_vec;

endmodule

// File: rtl/sec_irq_router.sv
module sec_irq_router
    import irq_route_pkg::*;
#(
    parameter int N_SRC = 8
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cpu_nonsecure_i,
    input  logic [N_SRC-1:0] src_set_i,
    input  logic             req_valid_i,
    input  logic             req_write_i,
    input  logic             req_secure_i,
    input  logic [2:0]       req_sel_i,
    input  logic [N_SRC-1:0] req_wdata_i,
    output logic             rd_valid_o,
    output logic [N_SRC-1:0] rd_data_o,
    output logic             irq_o,
    output logic             fiq_o
);

    reg_req_t         req;
    logic [N_SRC-1:0] grp, mod, en, pend;
    logic             irq_d, fiq_d;
    logic             past_ok;

    assign req = '{valid:  req_valid_i,
                   write:  req_write_i,
                   secure: req_secure_i,
                   sel:    reg_sel_e'(req_sel_i)};

    irq_cfg_regs #(.N_SRC(N_SRC)) u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .req_i     (req),
        .wdata_i   (req_wdata_i),
        .src_set_i (src_set_i),
        .grp_o     (grp),
        .mod_o     (mod),
        .en_o      (en),
        .pend_o    (pend),
        .rvalid_o  (rd_valid_o),
        .rdata_o   (rd_data_o)
    );

    irq_group_map #(.N_SRC(N_SRC)) u_map (
        .grp_i     (grp),
        .mod_i     (mod),
        .en_i      (en),
        .pend_i    (pend),
        .cpu_ns_i  (cpu_nonsecure_i),
        .irq_any_o (irq_d),
        .fiq_any_o (fiq_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            irq_o   <= 1'b0;
            fiq_o   <= 1'b0;
            past_ok <= 1'b0;
        end else begin
            irq_o   <= irq_d;
            fiq_o   <= fiq_d;
            past_ok <= 1'b1;
        end
    end

    // R2
    grp0_fiq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        past_ok && $past(|(en & pend & ~grp & ~mod)) |-> fiq_o);

    // R3
    sec1_secure_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        past_ok && $past(!cpu_nonsecure_i && |(en & pend & ~grp & mod)) |-> irq_o);

    // R4
    ns1_nonsecure_irq_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        past_ok && $past(cpu_nonsecure_i && |(en & pend & grp)) |-> irq_o);

    // R5
    disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        past_ok && $past(en == '0) |-> !irq_o && !fiq_o);

endmodule

// File: tb/tb_sec_irq_router.sv
module tb_sec_irq_router;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_ns = 1'b0;
    logic [N-1:0] src_set = '0;
    logic         req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [2:0]   req_sel = '0;
    logic [N-1:0] req_wdata = '0;
    logic         rd_valid;
    logic [N-1:0] rd_data;
    logic         irq, fiq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    sec_irq_router #(.N_SRC(N)) dut (
        .clk_i(clk), .rst_i(rst), .cpu_nonsecure_i(cpu_ns), .src_set_i(src_set),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_secure_i(req_secure),
        .req_sel_i(req_sel), .req_wdata_i(req_wdata), .rd_valid_o(rd_valid),
        .rd_data_o(rd_data), .irq_o(irq), .fiq_o(fiq)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_ns = 1'b0; src_set = '0; req_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // issue one request at a negedge; returns at the negedge after it takes effect
    task automatic req(input bit sec, input bit wr, input logic [2:0] sel, input logic [N-1:0] d);
        req_valid = 1'b1; req_write = wr; req_secure = sec; req_sel = sel; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input bit sec, input logic [2:0] sel, output logic [N-1:0] v);
        req(sec, 1'b0, sel, '0);
        v = rd_data;
    endtask

    task automatic settle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        do_reset();
        settle();
        check("R1 irq", N'(irq), '0);
        check("R1 fiq", N'(fiq), '0);
        rd(1, 3'd0, v); check("R1 group", v, '0);
        rd(1, 3'd1, v); check("R1 mod",   v, '0);
        rd(1, 3'd2, v); check("R1 enable", v, '0);
        rd(1, 3'd4, v); check("R1 pending", v, '0);
        check("R1 rd_valid", N'(rd_valid), N'(1));
    endtask

    task automatic t_grp0();
        do_reset();
        req(1, 1, 3'd2, 8'h01);
        req(1, 1, 3'd4, 8'h01);
        settle();
        check("R2 secure fiq", N'(fiq), N'(1));
        check("R2 secure irq", N'(irq), '0);
        cpu_ns = 1'b1; settle();
        check("R2 nonsecure fiq", N'(fiq), N'(1));
        check("R2 nonsecure irq", N'(irq), '0);
    endtask

    task automatic t_sg1();
        do_reset();
        req(1, 1, 3'd1, 8'h02);
        req(1, 1, 3'd2, 8'h02);
        req(1, 1, 3'd4, 8'h02);
        settle();
        check("R3 secure irq", N'(irq), N'(1));
        check("R3 secure fiq", N'(fiq), '0);
        cpu_ns = 1'b1; settle();
        check("R3 nonsecure irq", N'(irq), '0);
        check("R3 nonsecure fiq", N'(fiq), N'(1));
    endtask

    task automatic t_ns1();
        do_reset();
        req(1, 1, 3'd0, 8'h04);
        req(1, 1, 3'd2, 8'h04);
        req(1, 1, 3'd4, 8'h04);
        settle();
        check("R4 secure irq", N'(irq), '0);
        check("R4 secure fiq", N'(fiq), N'(1));
        cpu_ns = 1'b1; settle();
        check("R4 nonsecure irq", N'(irq), N'(1));
        check("R4 nonsecure fiq", N'(fiq), '0);
    endtask

    task automatic t_disabled();
        do_reset();
        req(1, 1, 3'd0, 8'hF0);
        req(1, 1, 3'd1, 8'h0C);
        req(1, 1, 3'd4, 8'hFF);
        settle();
        check("R5 secure irq", N'(irq), '0);
        check("R5 secure fiq", N'(fiq), '0);
        cpu_ns = 1'b1; settle();
        check("R5 nonsecure irq", N'(irq), '0);
        check("R5 nonsecure fiq", N'(fiq), '0);
    endtask

    task automatic t_grp_lock();
        logic [N-1:0] v;
        do_reset();
        req(1, 1, 3'd0, 8'hF0);
        req(0, 1, 3'd0, 8'h0F);
        rd(1, 3'd0, v); check("R6 group after ns write", v, 8'hF0);
        req(0, 1, 3'd1, 8'hFF);
        rd(1, 3'd1, v); check("R6 mod after ns write", v, 8'h00);
    endtask

    task automatic t_ns_write();
        logic [N-1:0] v;
        do_reset();
        req(1, 1, 3'd0, 8'hF0);
        req(0, 1, 3'd2, 8'hFF);
        rd(1, 3'd2, v); check("R7 ns enable-set", v, 8'hF0);
        req(0, 1, 3'd4, 8'hFF);
        rd(1, 3'd4, v); check("R7 ns pending-set", v, 8'hF0);
        req(1, 1, 3'd2, 8'h0F);
        rd(1, 3'd3, v); check("R7 secure enable-set", v, 8'hFF);
        req(0, 1, 3'd3, 8'hFF);
        rd(1, 3'd2, v); check("R7 ns enable-clear", v, 8'h0F);
        req(1, 1, 3'd4, 8'h0F);
        req(0, 1, 3'd5, 8'hFF);
        rd(1, 3'd5, v); check("R7 ns pending-clear", v, 8'h0F);
        req(1, 1, 3'd5, 8'hFF);
        rd(1, 3'd4, v); check("R7 secure pending-clear", v, 8'h00);
    endtask

    task automatic t_ns_read();
        logic [N-1:0] v;
        do_reset();
        req(1, 1, 3'd0, 8'hA5);
        req(1, 1, 3'd1, 8'h5A);
        req(1, 1, 3'd2, 8'hFF);
        req(1, 1, 3'd4, 8'hFF);
        rd(0, 3'd2, v); check("R8 ns enable read", v, 8'hA5);
        rd(0, 3'd5, v); check("R8 ns pending read", v, 8'hA5);
        rd(0, 3'd1, v); check("R8 ns mod read", v, 8'h00);
        rd(0, 3'd0, v); check("R8 ns group read", v, 8'hA5);
        rd(1, 3'd3, v); check("R8 secure enable read", v, 8'hFF);
        rd(1, 3'd1, v); check("R8 secure mod read", v, 8'h5A);
    endtask

    task automatic t_latency();
        do_reset();
        req(1, 1, 3'd2, 8'h08);
        req(1, 1, 3'd4, 8'h08);
        check("R9 fiq not yet", N'(fiq), '0);
        settle();
        check("R9 fiq one clock later", N'(fiq), N'(1));
        req(1, 1, 3'd5, 8'h08);
        check("R9 fiq held before update", N'(fiq), N'(1));
        settle();
        check("R9 fiq dropped", N'(fiq), '0);
    endtask

    task automatic t_src_set();
        logic [N-1:0] v;
        do_reset();
        src_set = 8'h40;
        @(posedge clk); @(negedge clk);
        src_set = '0;
        rd(1, 3'd4, v); check("R10 source sets pending", v, 8'h40);
        src_set = 8'h40;
        req(1, 1, 3'd5, 8'h40);
        src_set = '0;
        rd(1, 3'd4, v); check("R10 set beats clear", v, 8'h40);
        req(1, 1, 3'd5, 8'h40);
        rd(1, 3'd4, v); check("R10 clear alone", v, 8'h00);
    endtask

    task automatic t_regroup();
        do_reset();
        cpu_ns = 1'b1;
        req(1, 1, 3'd2, 8'h20);
        req(1, 1, 3'd4, 8'h20);
        settle();
        check("R11 before regroup fiq", N'(fiq), N'(1));
        req(1, 1, 3'd0, 8'h20);
        settle();
        check("R11 after regroup irq", N'(irq), N'(1));
        check("R11 after regroup fiq", N'(fiq), '0);
    endtask

    initial begin
        t_reset();
        t_grp0();
        t_sg1();
        t_ns1();
        t_disabled();
        t_grp_lock();
        t_ns_write();
        t_ns_read();
        t_latency();
        t_src_set();
        t_regroup();
        done = 1;
        summary();
    end

endmodule